// File: doc/BRIEF.md
# Burst-of-Two Double-Data-Rate SRAM Front End

This block is an on-chip memory with a common-data, double-data-rate interface that moves two words per command. The interface runs on a tick clock at twice the command rate. Every enabled tick is one half-cycle: a main-edge tick, then a complementary-edge tick. The block keeps its own phase and brings it out as `main_edge`. A command is sampled only on a main-edge tick. Write data arrives one cycle later as two beats. Read data leaves two cycles after the command, also as two beats, with the driver enable raised only for those beats.

Each 18-bit word is stored as two independent 9-bit halves, and each half has its own active-low write select on every beat. The second word of a burst sits at the partner address of an aligned pair, found by flipping address bit 0. A tick enable models a stopped clock: while it is low, nothing inside the block moves. The shared data bus is split into `dq_in`, `dq_out` and `dq_oe`, so the pad tri-state can sit outside the block.

Top module: `b2ddr_sram`

## Requirements
- R1: `main_edge` is 1 in the interval before the first enabled tick after reset, and it inverts after every enabled tick. A tick taken while `main_edge` is 1 is a main-edge tick.
- R2: During reset and right after it, `dq_oe` is 0.
- R3: On a main-edge tick, `ld_n`=0 with `rw`=0 starts a write, `ld_n`=0 with `rw`=1 starts a read, and `ld_n`=1 is a no-operation. Command inputs on complementary-edge ticks have no effect.
- R4: For a write accepted at tick c, `dq_in` and `wsel_n` are sampled at tick c+2 for address A and at tick c+3 for the partner address. On all other ticks they have no effect.
- R5: The partner address is A with bit 0 inverted, so a burst that starts at an odd address wraps to the even word of the same pair.
- R6: On a write beat, `wsel_n[0]`=0 stores `dq_in[8:0]` and `wsel_n[1]`=0 stores `dq_in[17:9]`. A select at 1 leaves that half unchanged. Each beat uses its own selects.
- R7: For a read accepted at tick c, after tick c+4 `dq_oe`=1 and `dq_out` holds word A. After tick c+5, `dq_oe`=1 and `dq_out` holds the partner word.
- R8: After every enabled tick that is not a read beat (no-operations, writes and idle slots), `dq_oe` is 0.
- R9: A read returns the effect of every write accepted before it, including a write on the immediately preceding cycle. It returns none of any later write, even one whose beats land on the same pair while the read burst is still being driven.
- R10: While `tick_en` is 0, all state and outputs hold, and every input is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one rising edge per half-cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Tick enable; low models a stopped clock |
| ld_n | input | 1 | Active-low command load strobe |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | ADDR_W | Burst start address |
| dq_in | input | 18 | Write data beats |
| wsel_n | input | 2 | Active-low per-half write selects |
| main_edge | output | 1 | 1 when the next enabled tick is a main edge |
| dq_out | output | 18 | Read data beats |
| dq_oe | output | 1 | Data driver enable; 0 means high-impedance |

## Verification
The hardest case to reach is a read whose burst overlaps the beats of a later write to the same pair. A write issued on the next command cycle to the odd word stores its first beat at the exact tick the read drives the even word, one tick before the read drives the odd word. To reach it, a directed read is followed at once by a write to the partner address. The random phase then confines addresses to sixteen words, puts a command on four main edges in five, stalls the tick enable in the middle of bursts, and drives live command values and random write selects on ticks where they must be ignored.

// File: rtl/b2ddr_pkg.sv
package b2ddr_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_WR   = 2'd1,
    OP_RD   = 2'd2
  } op_e;

  // Pipeline taps, counted in ticks after the command tick.
  localparam int WR_STG = 1;          // first write beat lands at tick c+2
  localparam int RD_STG = 3;          // first read beat driven at tick c+4
  localparam int PIPE_N = RD_STG + 2; // stages needed for the last read beat

  // Address of beat 0 or beat 1 within an aligned pair.
  function automatic logic [31:0] pair_addr(input logic [31:0] a, input logic beat);
    return {a[31:1], a[0] ^ beat};
  endfunction

endpackage

// File: rtl/b2ddr_cmd_pipe.sv
module b2ddr_cmd_pipe
  import b2ddr_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              ld_n,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  output logic              main_edge,
  output logic              wr_beat0,
  output logic              wr_beat1,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              rd_beat0,
  output logic              rd_beat1,
  output logic [ADDR_W-1:0] rd_addr
);

  logic              phase_q;
  op_e               op_q   [PIPE_N];
  logic [ADDR_W-1:0] addr_q [PIPE_N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      for (int i = 0; i < PIPE_N; i++) begin
        op_q[i]   <= OP_NONE;
        addr_q[i] <= '0;
      end
    end else if (tick_en) begin
      phase_q   <= ~phase_q;
      op_q[0]   <= (!phase_q && !ld_n) ? (rw ? OP_RD : OP_WR) : OP_NONE;
      addr_q[0] <= addr;
      for (int i = 1; i < PIPE_N; i++) begin
        op_q[i]   <= op_q[i-1];
        addr_q[i] <= addr_q[i-1];
      end
    end
  end

  assign main_edge = ~phase_q;

  assign wr_beat0 = tick_en && (op_q[WR_STG]   == OP_WR);
  assign wr_beat1 = tick_en && (op_q[WR_STG+1] == OP_WR);
  assign wr_addr  = wr_beat1 ? ADDR_W'(pair_addr(32'(addr_q[WR_STG+1]), 1'b1))
                             : addr_q[WR_STG];

  assign rd_beat0 = tick_en && (op_q[RD_STG]   == OP_RD);
  assign rd_beat1 = tick_en && (op_q[RD_STG+1] == OP_RD);
  assign rd_addr  = addr_q[RD_STG];

endmodule

// File: rtl/b2ddr_lane.sv
module b2ddr_lane
  import b2ddr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int HALF_W = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [HALF_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [HALF_W-1:0] rdata0,
  output logic [HALF_W-1:0] rdata1
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [HALF_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Both words of the pair are read at once, before any write of this tick.
  assign rdata0 = mem[raddr];
  assign rdata1 = mem[ADDR_W'(pair_addr(32'(raddr), 1'b1))];

endmodule

// File: rtl/b2ddr_rd_out.sv
module b2ddr_rd_out #(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              beat0,
  input  logic              beat1,
  input  logic [DATA_W-1:0] pair0,
  input  logic [DATA_W-1:0] pair1,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);

  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dq_out <= '0;
      hold_q <= '0;
      dq_oe  <= 1'b0;
    end else if (tick_en) begin
      if (beat0) begin
        dq_out <= pair0;
        hold_q <= pair1;
        dq_oe  <= 1'b1;
      end else if (beat1) begin
        dq_out <= hold_q;
        dq_oe  <= 1'b1;
      end else begin
        dq_oe  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/b2ddr_sram.sv
module b2ddr_sram #(
  parameter int ADDR_W = 6,
  parameter int HALF_W = 9,
  parameter int HALVES = 2,
  localparam int DATA_W = HALF_W * HALVES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              ld_n,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  input  logic [HALVES-1:0] wsel_n,
  output logic              main_edge,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);

  // Named internal events, used by the bound checker.
  logic              wr_beat0, wr_beat1, wr_fire;
  logic              rd_beat0, rd_beat1;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] pair0, pair1;

  b2ddr_cmd_pipe #(.ADDR_W(ADDR_W)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .ld_n     (ld_n),
    .rw       (rw),
    .addr     (addr),
    .main_edge(main_edge),
    .wr_beat0 (wr_beat0),
    .wr_beat1 (wr_beat1),
    .wr_addr  (wr_addr),
    .rd_beat0 (rd_beat0),
    .rd_beat1 (rd_beat1),
    .rd_addr  (rd_addr)
  );

  assign wr_fire = wr_beat0 | wr_beat1;

  for (genvar g = 0; g < HALVES; g++) begin : g_lane
    b2ddr_lane #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) u_lane (
      .clk   (clk),
      .we    (wr_fire && !wsel_n[g]),
      .waddr (wr_addr),
      .wdata (dq_in[g*HALF_W +: HALF_W]),
      .raddr (rd_addr),
      .rdata0(pair0[g*HALF_W +: HALF_W]),
      .rdata1(pair1[g*HALF_W +: HALF_W])
    );
  end

  b2ddr_rd_out #(.DATA_W(DATA_W)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_en(tick_en),
    .beat0  (rd_beat0),
    .beat1  (rd_beat1),
    .pair0  (pair0),
    .pair1  (pair1),
    .dq_out (dq_out),
    .dq_oe  (dq_oe)
  );

endmodule

// File: rtl/b2ddr_chk.sv
module b2ddr_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              main_edge,
  input logic              wr_beat0,
  input logic              wr_beat1,
  input logic              rd_beat0,
  input logic              rd_beat1,
  input logic [DATA_W-1:0] dq_out,
  input logic              dq_oe
);

  a_r1_phase_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> (main_edge != $past(main_edge)));

  a_r10_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> ($stable(dq_out) && $stable(dq_oe) && $stable(main_edge)));

  a_r7_drive_on_read_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && (rd_beat0 || rd_beat1)) |=> dq_oe);

  a_r8_hiz_elsewhere: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !rd_beat0 && !rd_beat1) |=> !dq_oe);

  a_r4_one_write_beat: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_beat0, wr_beat1}));

  a_r7_one_read_beat: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_beat0, rd_beat1}));

endmodule

bind b2ddr_sram b2ddr_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_en  (tick_en),
  .main_edge(main_edge),
  .wr_beat0 (wr_beat0),
  .wr_beat1 (wr_beat1),
  .rd_beat0 (rd_beat0),
  .rd_beat1 (rd_beat1),
  .dq_out   (dq_out),
  .dq_oe    (dq_oe)
);

// File: tb/b2ddr_sram_bench.sv
`timescale 1ns/1ps
module b2ddr_sram_bench;

  localparam int AW = 6;
  localparam int DW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_en = 1'b1;
  logic          ld_n = 1'b1;
  logic          rw = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [1:0]    wsel_n = 2'b11;
  logic          main_edge;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  b2ddr_sram #(.ADDR_W(AW)) u_b2ddr_sram (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ld_n(ld_n), .rw(rw),
    .addr(addr), .dq_in(dq_in), .wsel_n(wsel_n), .main_edge(main_edge),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  int tk = 0;

  logic [DW-1:0] ref_mem [1 << AW];
  bit            sd_v  [8];
  logic [DW-1:0] sd_dq [8];
  logic [1:0]    sd_m  [8];
  bit            ex_v  [8];
  logic [DW-1:0] ex_dq [8];
  string         ex_tag[8];

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                          input logic [DW-1:0] d,
                                          input logic [1:0] m);
    logic [DW-1:0] r;
    r[8:0]  = m[0] ? old_w[8:0]  : d[8:0];
    r[17:9] = m[1] ? old_w[17:9] : d[17:9];
    return r;
  endfunction

  function automatic logic [AW-1:0] partner(input logic [AW-1:0] a);
    return {a[AW-1:1], ~a[0]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s at tick %0d: actual=%h expected=%h", req, what, tk, act, exp);
    end
  endtask

  // One enabled tick: drive beat data, take the edge, check its outputs.
  task automatic tick();
    int s = tk % 8;
    if (sd_v[s]) begin
      dq_in  = sd_dq[s];
      wsel_n = sd_m[s];
      sd_v[s] = 1'b0;
    end else begin
      dq_in  = DW'($urandom);
      wsel_n = 2'($urandom);
    end
    @(posedge clk);
    @(negedge clk);
    if (ex_v[s]) begin
      check(dq_oe === 1'b1, "R7", "read beat enable", 32'(dq_oe), 32'd1);
      check(dq_out === ex_dq[s], ex_tag[s], "read beat data", 32'(dq_out), 32'(ex_dq[s]));
      ex_v[s] = 1'b0;
    end else begin
      check(dq_oe === 1'b0, "R8", "idle slot high-impedance", 32'(dq_oe), 32'd0);
    end
    tk++;
    check(main_edge === ((tk % 2) == 0), "R1", "phase", 32'(main_edge), 32'((tk % 2) == 0));
  endtask

  task automatic stall(input int n);
    logic [DW-1:0] q0 = dq_out;
    logic          e0 = dq_oe;
    logic          m0 = main_edge;
    tick_en = 1'b0;
    for (int i = 0; i < n; i++) begin
      ld_n = 1'b0; rw = 1'($urandom); addr = AW'($urandom);
      dq_in = DW'($urandom); wsel_n = 2'b00;
      @(posedge clk);
      @(negedge clk);
      check(dq_out === q0 && dq_oe === e0 && main_edge === m0, "R10",
            "stall hold", {dq_oe, main_edge, 12'd0, dq_out}, {e0, m0, 12'd0, q0});
    end
    tick_en = 1'b1;
  endtask

  // One command cycle: main tick with the command, optional stall, then the
  // complementary tick with live command values that must be ignored (R3).
  task automatic cycle(input logic l, input logic r, input logic [AW-1:0] a,
                       input logic [DW-1:0] d0, input logic [1:0] m0,
                       input logic [DW-1:0] d1, input logic [1:0] m1,
                       input int stl, input string tg);
    int c = tk;
    ld_n = l; rw = r; addr = a;
    if (!l && !r) begin
      sd_v[(c+2)%8] = 1'b1; sd_dq[(c+2)%8] = d0; sd_m[(c+2)%8] = m0;
      sd_v[(c+3)%8] = 1'b1; sd_dq[(c+3)%8] = d1; sd_m[(c+3)%8] = m1;
      ref_mem[a]          = merge(ref_mem[a], d0, m0);
      ref_mem[partner(a)] = merge(ref_mem[partner(a)], d1, m1);
    end else if (!l && r) begin
      ex_v[(c+4)%8] = 1'b1; ex_dq[(c+4)%8] = ref_mem[a];          ex_tag[(c+4)%8] = tg;
      ex_v[(c+5)%8] = 1'b1; ex_dq[(c+5)%8] = ref_mem[partner(a)]; ex_tag[(c+5)%8] = tg;
    end
    tick();
    if (stl > 0) stall(stl);
    ld_n = 1'($urandom); rw = 1'($urandom); addr = AW'($urandom);
    tick();
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tg);
    cycle(1'b0, 1'b1, a, '0, 2'b11, '0, 2'b11, 0, tg);
  endtask

  task automatic nop(input string tg);
    cycle(1'b1, 1'b0, '0, '0, 2'b11, '0, 2'b11, 0, tg);
  endtask

  initial begin
    #600000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h2b1d7));
    for (int i = 0; i < 8; i++) begin
      sd_v[i] = 1'b0; ex_v[i] = 1'b0; sd_m[i] = 2'b11; ex_tag[i] = "";
    end

    // Reset state (R2, R1)
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(dq_oe === 1'b0, "R2", "enable in reset", 32'(dq_oe), 32'd0);
    rst_n = 1'b1;
    check(dq_oe === 1'b0, "R2", "enable after reset", 32'(dq_oe), 32'd0);
    check(main_edge === 1'b1, "R1", "first tick is main", 32'(main_edge), 32'd1);

    // Fill every pair with full-width writes (R4)
    for (int i = 0; i < (1 << (AW-1)); i++)
      cycle(1'b0, 1'b0, AW'(2*i), DW'($urandom), 2'b00, DW'($urandom), 2'b00, 0, "R4");
    for (int i = 0; i < (1 << (AW-1)); i++)
      rd(AW'(2*i), "R4");

    // Odd start address wraps within the pair, read right after the write (R5, R9)
    cycle(1'b0, 1'b0, 6'd5, 18'h2aaaa, 2'b00, 18'h15555, 2'b00, 0, "R5");
    rd(6'd4, "R5");
    rd(6'd5, "R5");

    // Different half selects on each beat (R6)
    cycle(1'b0, 1'b0, 6'd8, 18'h3ffff, 2'b10, 18'h3ffff, 2'b01, 0, "R6");
    rd(6'd8, "R6");
    // Both selects high on both beats: nothing written (R6)
    cycle(1'b0, 1'b0, 6'd10, 18'h0, 2'b11, 18'h0, 2'b11, 0, "R6");
    rd(6'd10, "R6");

    // Read, then a write to the odd partner that lands during the read burst (R9)
    rd(6'd12, "R9");
    cycle(1'b0, 1'b0, 6'd13, 18'h01234, 2'b00, 18'h3cdef, 2'b00, 0, "R9");
    rd(6'd12, "R9");

    // No-operations with stray complementary-tick commands, then a read (R3, R8)
    repeat (4) nop("R3");
    rd(6'd20, "R3");

    // Stalls between the halves of a write and a read (R10)
    cycle(1'b0, 1'b0, 6'd14, 18'h0beef, 2'b00, 18'h3f00d, 2'b00, 3, "R10");
    cycle(1'b0, 1'b1, 6'd14, '0, 2'b11, '0, 2'b11, 2, "R10");
    nop("R10");
    stall(2);
    rd(6'd15, "R10");

    // Random mix on a small address window
    for (int i = 0; i < 3000; i++) begin
      logic l = ($urandom % 10) < 2;
      logic r = 1'($urandom);
      int   st = (($urandom % 20) == 0) ? int'(1 + $urandom % 3) : 0;
      cycle(l, r, AW'($urandom % 16), DW'($urandom), 2'($urandom),
            DW'($urandom), 2'($urandom), st, "R9");
    end

    repeat (4) nop("R8");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule